// File: doc/BRIEF.md
# Synchronous Slave FIFO Device Model

This block stands in for the device side of a synchronous slave FIFO bridge, so that an external master design can be exercised against realistic flag and strobe behaviour. It contains four endpoint buffers. A two-bit address picks one of them, and every transfer is sampled on the rising edge of the interface clock. The two lower codes select endpoints that carry data from the host toward the master (OUT). The two upper codes select endpoints that carry data from the master toward the host (IN).

The master drives active-low strobes for chip select, read, write, output enable and packet end. The model drives three registered active-low flags that describe the addressed endpoint. An IN packet is committed automatically once it reaches the preset size. The master can also commit a shorter packet early with the packet-end strobe. Each endpoint holds two packet slots. A host-side port lets a testbench load OUT packets word by word and drain committed IN packets, with a marker on the final word of each packet.

Top module: `sfe_top`

## Requirements
- R1: Address code 00 and 01 select the two OUT endpoints and 10 and 11 select the two IN endpoints. A master read strobe aimed at an IN endpoint, or a master write strobe aimed at an OUT endpoint, has no effect.
- R2: Master read, write and packet-end strobes act only while the active-low chip select `cs_n` is 0.
- R3: While a strobe is low, exactly one bus word moves on each rising clock edge, for bursts of any length.
- R4: Flags are active low and describe the addressed endpoint one clock after the edge that changes its state or the address. During reset they read empty_n=0, full_n=1, prog_n=1.
- R5: An IN endpoint commits its open packet by itself once it holds PKT_BYTES/(DW/8) words, which is 256 words of 16 bits by default.
- R6: A packet-end strobe commits the open IN packet as a short packet. A write and a packet end on the same edge commit a packet that includes that word.
- R7: Each read advances the endpoint's read position by one, so words leave in the order they were stored. On the host side, `host_pop_last` is 1 on the final word of each packet.
- R8: The data bus is driven only while `cs_n` and `oe_n` are both 0 and an OUT endpoint is addressed. Otherwise it is high impedance.
- R9: A write to a full endpoint is ignored and leaves the stored data unchanged.
- R10: A read from an empty endpoint is ignored and leaves the read position unchanged.
- R11: Each endpoint stores at most two packets. Full (flag_full_n=0) means two committed packets.
- R12: flag_prog_n is 0 while the addressed endpoint stores at least PROG_LEVEL words (default 64), counting uncommitted words.
- R13: Host pushes into an OUT endpoint commit a packet on `host_push_last` or at the packet size. `host_push_ready` is 1 only for an addressed OUT endpoint that is not full.
- R14: A packet-end strobe with no open words is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Active-low reset |
| ep_sel | input | 2 | Master endpoint address |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Bus output enable, active low |
| pktend_n | input | 1 | Packet-end strobe, active low |
| fd | inout | DW | Bidirectional data bus |
| flag_prog_n | output | 1 | Programmable-level flag, active low |
| flag_full_n | output | 1 | Full flag, active low |
| flag_empty_n | output | 1 | Empty flag, active low |
| host_sel | input | 2 | Host-side endpoint address |
| host_push | input | 1 | Host writes a word into an OUT endpoint |
| host_push_data | input | DW | Word pushed by the host |
| host_push_last | input | 1 | Pushed word closes the packet |
| host_push_ready | output | 1 | Addressed OUT endpoint can accept a word |
| host_pop | input | 1 | Host removes a committed IN word |
| host_pop_data | output | DW | Head word of the addressed IN endpoint |
| host_pop_valid | output | 1 | A committed IN word is available |
| host_pop_last | output | 1 | Head word ends its packet |

## Verification
Four properties are checked on every cycle: full and empty are never shown together, stored counts never exceed two packets, host pops are offered only on IN endpoints, and a strobe that meets a full or empty flag leaves that endpoint's count unchanged. Other behaviours can only be shown by the bench's scenarios, which compare data with a scoreboard. These are word ordering, the exact edge at which a packet commits (automatically at 256 words, or early with a packet end on its own or on the same edge as a write), the flag thresholds, and the bus release when output enable or chip select is high.

// File: rtl/sfe_pkg.sv
package sfe_pkg;

    localparam int unsigned NUM_EP = 4;

    typedef struct packed {
        logic prog_n;
        logic full_n;
        logic empty_n;
    } sfe_flags_t;

    // Upper address bit marks endpoints that the master fills
    function automatic logic ep_is_in(input logic [1:0] code);
        return code[1];
    endfunction

endpackage

// File: rtl/sfe_pkt_buf.sv
module sfe_pkt_buf #(
    parameter int unsigned DW        = 16,
    parameter int unsigned PKT_WORDS = 256,
    parameter int unsigned LW        = $clog2(2 * PKT_WORDS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          commit,
    input  logic          rd_en,
    output logic [DW-1:0] rd_data,
    output logic          rd_avail,
    output logic          rd_last,
    output logic          full,
    output logic          avail_nx,
    output logic          full_nx,
    output logic [LW-1:0] level_nx
);

    localparam int unsigned DEPTH = 2 * PKT_WORDS;
    localparam int unsigned AW    = $clog2(DEPTH);
    localparam int unsigned CW    = $clog2(PKT_WORDS + 1);

    typedef struct packed {
        logic                wslot;
        logic [CW-1:0]       widx;
        logic [1:0][CW-1:0]  len;
        logic                rslot;
        logic [CW-1:0]       ridx;
        logic [1:0]          ncommit;
        logic [LW-1:0]       level;
    } buf_state_t;

    buf_state_t st_d, st_q;

    logic [DW-1:0] mem [DEPTH];

    logic          do_wr, do_rd, close_pkt, head_last;
    logic [CW-1:0] widx_inc, close_len, cur_len;
    logic [AW-1:0] waddr, raddr;

    function automatic logic [AW-1:0] slot_addr(input logic slot, input logic [CW-1:0] idx);
        return slot ? AW'(PKT_WORDS) + AW'(idx) : AW'(idx);
    endfunction

    assign cur_len   = st_q.len[st_q.rslot];
    assign head_last = (st_q.ridx == cur_len - CW'(1));
    assign waddr     = slot_addr(st_q.wslot, st_q.widx);
    assign raddr     = slot_addr(st_q.rslot, st_q.ridx);

    always_comb begin
        st_d      = st_q;
        do_wr     = wr_en && (st_q.ncommit != 2'd2);
        do_rd     = rd_en && (st_q.ncommit != 2'd0);
        widx_inc  = st_q.widx + CW'(1);
        close_pkt = 1'b0;
        close_len = '0;

        if (do_wr) begin
            if ((widx_inc == CW'(PKT_WORDS)) || commit) begin
                close_pkt = 1'b1;
                close_len = widx_inc;
            end else begin
                st_d.widx = widx_inc;
            end
        end else if (commit && (st_q.widx != '0) && (st_q.ncommit != 2'd2)) begin
            close_pkt = 1'b1;
            close_len = st_q.widx;
        end

        if (close_pkt) begin
            st_d.len[st_q.wslot] = close_len;
            st_d.wslot           = ~st_q.wslot;
            st_d.widx            = '0;
        end

        if (do_rd) begin
            if (head_last) begin
                st_d.ridx  = '0;
                st_d.rslot = ~st_q.rslot;
            end else begin
                st_d.ridx = st_q.ridx + CW'(1);
            end
        end

        st_d.ncommit = st_q.ncommit + {1'b0, close_pkt} - {1'b0, do_rd && head_last};
        st_d.level   = st_q.level + LW'(do_wr) - LW'(do_rd);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        if (do_wr) begin
            mem[waddr] <= wr_data;
        end
    end

    assign rd_data  = mem[raddr];
    assign rd_avail = (st_q.ncommit != 2'd0);
    assign rd_last  = head_last;
    assign full     = (st_q.ncommit == 2'd2);
    assign avail_nx = (st_d.ncommit != 2'd0);
    assign full_nx  = (st_d.ncommit == 2'd2);
    assign level_nx = st_d.level;

endmodule

// File: rtl/sfe_flag_unit.sv
module sfe_flag_unit
    import sfe_pkg::*;
#(
    parameter int unsigned LW         = 10,
    parameter int unsigned PROG_LEVEL = 64
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [1:0]             sel,
    input  logic [NUM_EP-1:0]      ep_full_nx,
    input  logic [NUM_EP-1:0]      ep_avail_nx,
    input  logic [NUM_EP-1:0][LW-1:0] ep_level_nx,
    output sfe_flags_t             flags
);

    sfe_flags_t    flags_d, flags_q;
    logic [LW-1:0] sel_level;
    logic          sel_empty;

    always_comb begin
        sel_level = ep_level_nx[sel];
        // IN endpoints read empty only with no words at all; OUT ones need a committed packet
        sel_empty = ep_is_in(sel) ? (sel_level == '0) : !ep_avail_nx[sel];
        flags_d.prog_n  = !(sel_level >= LW'(PROG_LEVEL));
        flags_d.full_n  = !ep_full_nx[sel];
        flags_d.empty_n = !sel_empty;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '{prog_n: 1'b1, full_n: 1'b1, empty_n: 1'b0};
        end else begin
            flags_q <= flags_d;
        end
    end

    assign flags = flags_q;

endmodule

// File: rtl/sfe_top.sv
module sfe_top
    import sfe_pkg::*;
#(
    parameter int unsigned DW         = 16,
    parameter int unsigned PKT_BYTES  = 512,
    parameter int unsigned PROG_LEVEL = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    ep_sel,
    input  logic          cs_n,
    input  logic          rd_n,
    input  logic          wr_n,
    input  logic          oe_n,
    input  logic          pktend_n,
    inout  wire  [DW-1:0] fd,
    output logic          flag_prog_n,
    output logic          flag_full_n,
    output logic          flag_empty_n,
    input  logic [1:0]    host_sel,
    input  logic          host_push,
    input  logic [DW-1:0] host_push_data,
    input  logic          host_push_last,
    output logic          host_push_ready,
    input  logic          host_pop,
    output logic [DW-1:0] host_pop_data,
    output logic          host_pop_valid,
    output logic          host_pop_last
);

    localparam int unsigned PKT_WORDS = PKT_BYTES / (DW / 8);
    localparam int unsigned LW        = $clog2(2 * PKT_WORDS + 1);

    logic [DW-1:0]             ep_rdata [NUM_EP];
    logic [NUM_EP-1:0]         ep_avail, ep_last, ep_full;
    logic [NUM_EP-1:0]         ep_avail_nx, ep_full_nx;
    logic [NUM_EP-1:0][LW-1:0] ep_level_nx;
    sfe_flags_t                flags;
    logic                      bus_drive;

    for (genvar gi = 0; gi < NUM_EP; gi++) begin : g_ep
        localparam logic [1:0] CODE = 2'(gi);

        logic          m_hit, h_hit;
        logic          b_wr, b_commit, b_rd;
        logic [DW-1:0] b_wdata;

        assign m_hit = !cs_n && (ep_sel == CODE);
        assign h_hit = (host_sel == CODE);

        if (CODE[1]) begin : g_in
            assign b_wr     = m_hit && !wr_n;
            assign b_wdata  = fd;
            assign b_commit = m_hit && !pktend_n;
            assign b_rd     = h_hit && host_pop;
        end else begin : g_out
            assign b_wr     = h_hit && host_push;
            assign b_wdata  = host_push_data;
            assign b_commit = h_hit && host_push && host_push_last;
            assign b_rd     = m_hit && !rd_n;
        end

        sfe_pkt_buf #(
            .DW        (DW),
            .PKT_WORDS (PKT_WORDS),
            .LW        (LW)
        ) u_buf (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (b_wr),
            .wr_data  (b_wdata),
            .commit   (b_commit),
            .rd_en    (b_rd),
            .rd_data  (ep_rdata[gi]),
            .rd_avail (ep_avail[gi]),
            .rd_last  (ep_last[gi]),
            .full     (ep_full[gi]),
            .avail_nx (ep_avail_nx[gi]),
            .full_nx  (ep_full_nx[gi]),
            .level_nx (ep_level_nx[gi])
        );
    end

    sfe_flag_unit #(
        .LW         (LW),
        .PROG_LEVEL (PROG_LEVEL)
    ) u_flags (
        .clk         (clk),
        .rst_n       (rst_n),
        .sel         (ep_sel),
        .ep_full_nx  (ep_full_nx),
        .ep_avail_nx (ep_avail_nx),
        .ep_level_nx (ep_level_nx),
        .flags       (flags)
    );

    assign flag_prog_n  = flags.prog_n;
    assign flag_full_n  = flags.full_n;
    assign flag_empty_n = flags.empty_n;

    assign bus_drive = !cs_n && !oe_n && !ep_is_in(ep_sel);
    assign fd        = bus_drive ? ep_rdata[ep_sel] : {DW{1'bz}};

    assign host_push_ready = !ep_is_in(host_sel) && !ep_full[host_sel];
    assign host_pop_valid  = ep_is_in(host_sel) && ep_avail[host_sel];
    assign host_pop_data   = ep_rdata[host_sel];
    assign host_pop_last   = ep_last[host_sel];

endmodule

// File: rtl/sfe_checker.sv
module sfe_checker #(
    parameter int unsigned LW   = 10,
    parameter int unsigned MAXL = 512
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       ep_sel,
    input logic             cs_n,
    input logic             rd_n,
    input logic             wr_n,
    input logic [1:0]       host_sel,
    input logic             host_push,
    input logic             host_pop,
    input logic             host_pop_valid,
    input logic             flag_full_n,
    input logic             flag_empty_n,
    input logic [3:0][LW-1:0] lvl_nx
);

    logic [1:0]          sel_q;
    logic [3:0][LW-1:0]  lvl_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= '0;
            lvl_q <= '0;
        end else begin
            sel_q <= ep_sel;
            lvl_q <= lvl_nx;
        end
    end

    a_r4_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(!flag_full_n && !flag_empty_n));

    for (genvar gi = 0; gi < 4; gi++) begin : g_bound
        a_r11_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
            lvl_nx[gi] <= LW'(MAXL));
    end

    a_r1_pop_only_in: assert property (@(posedge clk) disable iff (!rst_n)
        host_pop_valid |-> host_sel[1]);

    a_r9_full_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !wr_n && ep_sel[1] && !flag_full_n && (ep_sel == sel_q)
         && !(host_pop && (host_sel == ep_sel)))
        |-> (lvl_nx[ep_sel] == lvl_q[ep_sel]));

    a_r10_empty_read_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !rd_n && !ep_sel[1] && !flag_empty_n && (ep_sel == sel_q)
         && !(host_push && (host_sel == ep_sel)))
        |-> (lvl_nx[ep_sel] == lvl_q[ep_sel]));

endmodule

bind sfe_top sfe_checker #(
    .LW   (LW),
    .MAXL (2 * PKT_WORDS)
) chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .ep_sel         (ep_sel),
    .cs_n           (cs_n),
    .rd_n           (rd_n),
    .wr_n           (wr_n),
    .host_sel       (host_sel),
    .host_push      (host_push),
    .host_pop       (host_pop),
    .host_pop_valid (host_pop_valid),
    .flag_full_n    (flag_full_n),
    .flag_empty_n   (flag_empty_n),
    .lvl_nx         (ep_level_nx)
);

// File: tb/sfe_top_tb_top.sv
module sfe_top_tb_top;

    localparam int DW  = 16;
    localparam int PKT = 256;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [1:0]    ep_sel;
    logic          cs_n, rd_n, wr_n, oe_n, pktend_n;
    wire  [DW-1:0] fd;
    logic          flag_prog_n, flag_full_n, flag_empty_n;
    logic [1:0]    host_sel;
    logic          host_push, host_push_last, host_push_ready;
    logic [DW-1:0] host_push_data, host_pop_data;
    logic          host_pop, host_pop_valid, host_pop_last;

    logic          tb_drv;
    logic [DW-1:0] tb_dat;
    assign fd = tb_drv ? tb_dat : {DW{1'bz}};

    always #2 clk = ~clk;

    sfe_top dut_i (
        .clk(clk), .rst_n(rst_n), .ep_sel(ep_sel), .cs_n(cs_n), .rd_n(rd_n),
        .wr_n(wr_n), .oe_n(oe_n), .pktend_n(pktend_n), .fd(fd),
        .flag_prog_n(flag_prog_n), .flag_full_n(flag_full_n), .flag_empty_n(flag_empty_n),
        .host_sel(host_sel), .host_push(host_push), .host_push_data(host_push_data),
        .host_push_last(host_push_last), .host_push_ready(host_push_ready),
        .host_pop(host_pop), .host_pop_data(host_pop_data),
        .host_pop_valid(host_pop_valid), .host_pop_last(host_pop_last)
    );

    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 1'b0;
    bit          mon_rd = 1'b0;
    bit          mon_pop = 1'b0;
    logic [DW:0] exp_q [4][$];
    int          open_cnt [4];

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
        end
    endtask

    // Scoreboard monitor: compares data leaving either side against the queues
    always @(negedge clk) begin
        logic [DW:0] e;
        #1;
        if (mon_rd) begin
            if (exp_q[ep_sel].size() == 0) begin
                chk("R7 unexpected master read", 32'(fd), 32'hdead);
            end else begin
                e = exp_q[ep_sel].pop_front();
                chk("R7 R3 master read data", 32'(fd), 32'(e[DW-1:0]));
            end
        end
        if (mon_pop) begin
            chk("R7 host pop valid", 32'(host_pop_valid), 32'd1);
            if (exp_q[host_sel].size() == 0) begin
                chk("R7 unexpected host pop", 32'(host_pop_data), 32'hdead);
            end else begin
                e = exp_q[host_sel].pop_front();
                chk("R7 host pop data", 32'(host_pop_data), 32'(e[DW-1:0]));
                chk("R7 host pop last", 32'(host_pop_last), 32'(e[DW]));
            end
        end
    end

    task automatic idle();
        cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1; oe_n = 1'b1; pktend_n = 1'b1;
        tb_drv = 1'b0; host_push = 1'b0; host_push_last = 1'b0; host_pop = 1'b0;
        mon_rd = 1'b0; mon_pop = 1'b0;
    endtask

    task automatic set_sel(input logic [1:0] e);
        @(negedge clk);
        ep_sel = e;
        @(negedge clk);
        #1;
    endtask

    task automatic mwrite(input int ep, input int n, input int base, input bit pend_last, input bit store);
        logic lst;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            cs_n = 1'b0; wr_n = 1'b0; tb_drv = 1'b1; tb_dat = DW'(base + k);
            pktend_n = !(pend_last && (k == n - 1));
            if (store) begin
                open_cnt[ep]++;
                lst = (open_cnt[ep] == PKT) || (pend_last && (k == n - 1));
                if (lst) open_cnt[ep] = 0;
                exp_q[ep].push_back({lst, DW'(base + k)});
            end
        end
        @(negedge clk);
        idle();
        #1;
    endtask

    task automatic pend_only(input int ep, input bit has_data);
        @(negedge clk);
        cs_n = 1'b0; pktend_n = 1'b0;
        if (has_data) begin
            exp_q[ep][exp_q[ep].size() - 1][DW] = 1'b1;
            open_cnt[ep] = 0;
        end
        @(negedge clk);
        idle();
        #1;
    endtask

    task automatic mread(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            cs_n = 1'b0; oe_n = 1'b0; rd_n = 1'b0; mon_rd = 1'b1;
        end
        @(negedge clk);
        idle();
        #1;
    endtask

    task automatic hpush(input int ep, input int n, input int base, input bit last_at_end);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            host_sel = 2'(ep); host_push = 1'b1; host_push_data = DW'(base + k);
            host_push_last = last_at_end && (k == n - 1);
            exp_q[ep].push_back({1'b0, DW'(base + k)});
        end
        @(negedge clk);
        idle();
        #1;
    endtask

    task automatic hpop(input int ep, input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            host_sel = 2'(ep); host_pop = 1'b1; mon_pop = 1'b1;
        end
        @(negedge clk);
        idle();
        #1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 4; i++) open_cnt[i] = 0;
        idle();
        rst_n = 1'b0; ep_sel = 2'd0; host_sel = 2'd0;
        host_push_data = '0; tb_dat = '0;
        repeat (4) @(negedge clk);
        #1;
        chk("R4 reset empty_n", 32'(flag_empty_n), 32'd0);
        chk("R4 reset full_n", 32'(flag_full_n), 32'd1);
        chk("R4 reset prog_n", 32'(flag_prog_n), 32'd1);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;

        // R10: read attempts on an empty OUT endpoint
        @(negedge clk);
        cs_n = 1'b0; rd_n = 1'b0;
        repeat (2) @(negedge clk);
        idle();
        #1;
        chk("R10 empty flag after empty reads", 32'(flag_empty_n), 32'd0);

        // R13 R7: short host packet then master reads it back
        hpush(0, 3, 16'h0100, 1'b1);
        chk("R13 OUT packet committed by last", 32'(flag_empty_n), 32'd1);
        host_sel = 2'd0;
        #1;
        chk("R13 push ready on OUT", 32'(host_push_ready), 32'd1);
        mread(3);
        chk("R4 empty after draining", 32'(flag_empty_n), 32'd0);

        // R1: wrong-direction strobes
        host_sel = 2'd0;
        #1;
        chk("R1 no host pop on OUT", 32'(host_pop_valid), 32'd0);
        mwrite(0, 2, 16'h7700, 1'b0, 1'b0);
        chk("R1 write to OUT endpoint ignored", 32'(flag_prog_n), 32'd1);
        set_sel(2);
        @(negedge clk);
        cs_n = 1'b0; rd_n = 1'b0;
        @(negedge clk);
        idle();
        #1;
        chk("R1 IN endpoint still empty", 32'(flag_empty_n), 32'd0);

        // R5: automatic commit at packet size
        host_sel = 2'd2;
        mwrite(2, PKT - 1, 16'h1000, 1'b0, 1'b1);
        chk("R5 no commit before size", 32'(host_pop_valid), 32'd0);
        chk("R12 prog low above level", 32'(flag_prog_n), 32'd0);
        chk("R4 not empty after writes", 32'(flag_empty_n), 32'd1);
        mwrite(2, 1, 16'h1000 + PKT - 1, 1'b0, 1'b1);
        chk("R5 commit at size", 32'(host_pop_valid), 32'd1);
        chk("R11 one packet not full", 32'(flag_full_n), 32'd1);
        hpop(2, PKT);
        chk("R7 drained", 32'(host_pop_valid), 32'd0);

        // R6 R14: packet-end forms short packets
        set_sel(3);
        host_sel = 2'd3;
        mwrite(3, 5, 16'h3000, 1'b0, 1'b1);
        chk("R6 open packet not visible", 32'(host_pop_valid), 32'd0);
        pend_only(3, 1'b1);
        chk("R6 short packet committed", 32'(host_pop_valid), 32'd1);
        hpop(3, 5);
        pend_only(3, 1'b0);
        chk("R14 empty packet end ignored", 32'(host_pop_valid), 32'd0);
        mwrite(3, 3, 16'h3100, 1'b1, 1'b1);
        chk("R6 same-edge write and end", 32'(host_pop_valid), 32'd1);
        hpop(3, 3);

        // R12 R11 R9: threshold, two-packet capacity, writes when full
        set_sel(2);
        mwrite(2, 63, 16'h5000, 1'b0, 1'b1);
        chk("R12 prog high below level", 32'(flag_prog_n), 32'd1);
        mwrite(2, 1, 16'h5000 + 63, 1'b0, 1'b1);
        chk("R12 prog low at level", 32'(flag_prog_n), 32'd0);
        mwrite(2, 2 * PKT - 64, 16'h5000 + 64, 1'b0, 1'b1);
        chk("R11 full after two packets", 32'(flag_full_n), 32'd0);
        mwrite(2, 4, 16'hEE00, 1'b0, 1'b0);
        chk("R9 still full", 32'(flag_full_n), 32'd0);
        hpop(2, 2 * PKT);
        host_sel = 2'd2;
        #1;
        chk("R9 no extra words stored", 32'(host_pop_valid), 32'd0);

        // R8: bus release
        set_sel(0);
        hpush(0, 1, 16'h1234, 1'b1);
        @(negedge clk);
        cs_n = 1'b0; oe_n = 1'b1; tb_drv = 1'b1; tb_dat = 16'hBEEF;
        #1;
        chk("R8 released with oe_n high", 32'(fd), 32'hBEEF);
        cs_n = 1'b1; oe_n = 1'b0;
        #1;
        chk("R8 released with cs_n high", 32'(fd), 32'hBEEF);
        tb_drv = 1'b0; cs_n = 1'b0;
        #1;
        chk("R8 driven when enabled", 32'(fd), 32'h1234);
        idle();
        mread(1);

        // R2: strobes ignored without chip select
        set_sel(2);
        @(negedge clk);
        cs_n = 1'b1; wr_n = 1'b0; tb_drv = 1'b1; tb_dat = 16'hAAAA;
        repeat (3) @(negedge clk);
        idle();
        #1;
        chk("R2 write without select ignored", 32'(flag_empty_n), 32'd0);
        host_sel = 2'd2;
        #1;
        chk("R2 nothing to pop", 32'(host_pop_valid), 32'd0);

        // R13: OUT packet committed at size without last
        set_sel(1);
        hpush(1, PKT, 16'h4000, 1'b0);
        chk("R13 OUT committed at size", 32'(flag_empty_n), 32'd1);
        host_sel = 2'd1;
        #1;
        chk("R13 ready with one packet", 32'(host_push_ready), 32'd1);
        mread(PKT);
        chk("R4 OUT empty after reading", 32'(flag_empty_n), 32'd0);

        for (int i = 0; i < 4; i++) begin
            chk("R7 scoreboard drained", 32'(exp_q[i].size()), 32'd0);
        end
        finish_run();
    end

endmodule